// File: doc/BRIEF.md
# Adaptive spectral subtraction engine

This block sits between a forward and an inverse 64-point transform in a speech clean-up path. It takes one complex bin at a time and looks up a per-bin noise power estimate. It scales the bin's real and imaginary parts by a subtraction gain and hands the result back with a one-cycle acknowledge. The gain needs a ratio and a square root. Both come from small iterative units, so only one bin is in flight at a time. The caller presents the next bin only after the acknowledge for the previous one.

Across a frame of 64 bins, the block adds up the input power and an estimate of the cleaned power. For the first eight frames after reset, it builds the noise estimate as a per-bin mean of the input power. After that, it updates the noise estimate only after frames whose cleaned energy is small compared with their input energy. Those frames are judged to hold noise alone. The update happens after the frame's last bin, from a copy of that frame's bin powers, and it takes 64 cycles. All scale factors are powers of two and are applied as shifts.

Top module: `spec_sub_engine`

## Requirements
- R1: After reset, `ack_o` is low, both outputs are zero and every noise estimate is zero. As a result, bins of the first frame with nonzero power leave the block unchanged.
- R2: With bin power P = re² + im² and noise estimate N for the bin, when 8N ≥ P the gain is the floor value 2048, which is 1/16 in Q1.15.
- R3: When 8N < P, the gain is floor(sqrt((65536 − floor(8N·65536/P)) · 2^14)) in Q1.15. This value never exceeds 32768.
- R4: Each output part equals the input part times the gain, arithmetically shifted right by 15 and kept to 16 bits. `ack_o` is high for exactly one cycle for each accepted bin.
- R5: Accepted bins are numbered 0 to 63 in arrival order, and the number selects the noise entry. A frame is 64 accepted bins, and numbering restarts at 0 after each frame.
- R6: After each of the first 8 frames, every entry becomes N + (P >> 3), where P is that bin's power in the frame just ended.
- R7: From the ninth frame on, a frame counts as noise-only when the sum of clean power is below half the sum of P. Clean power is P − 8N for a bin in the R3 case and P >> 8 for a floored bin.
- R8: After a noise-only frame, each entry becomes N − (N >> 3) + (P >> 3). After any other frame past training, the estimates are left unchanged.
- R9: A frame that triggers an update is followed by a 64-cycle update window, which starts with the cycle in which that frame's last `ack_o` is high. A load during this window gets no acknowledge and does not advance the bin number.
- R10: A load that arrives while a bin is still being processed is ignored. It produces no acknowledge and does not change the result of the bin in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| load_i | input | 1 | A bin is present on the inputs this cycle |
| re_i | input | 16 | Real part of the bin, signed |
| im_i | input | 16 | Imaginary part of the bin, signed |
| ack_o | output | 1 | One-cycle pulse: the outputs hold a processed bin |
| re_o | output | 16 | Real part after the gain, signed |
| im_o | output | 16 | Imaginary part after the gain, signed |

## Verification
The assertions check four things every cycle:
- When the divider finishes, its quotient is the exact floored fraction of its operands.
- When the root unit finishes, its result is the exact integer square root.
- The gain never exceeds unity, floored bins carry exactly the floor gain, and acknowledge pulses are single cycles.
- No output is larger in magnitude than its input, and bin numbering is at zero whenever an update runs.

The bench's scenarios have to show what spans frames. It runs a training run, a noise-only frame followed by its update, and a loud frame that must leave the estimate untouched. These reveal whether the right update rule ran, and whether one ran at all, only through the values of later frames. The same holds for the ignored loads during processing and during the update window.

// File: rtl/sse_pkg.sv
package sse_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_DIV  = 3'd1,
        S_SQRT = 3'd2,
        S_OUT  = 3'd3,
        S_UPD  = 3'd4
    } sse_state_e;

endpackage

// File: rtl/sse_bin_ram.sv
module sse_bin_ram #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [WIDTH-1:0]         wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [WIDTH-1:0]         rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/sse_frac_div.sv
// Restoring divider producing floor(num * 2^QW / den) for num < den.
module sse_frac_div #(
    parameter int W  = 32,
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  num,
    input  logic [W-1:0]  den,
    output logic          done,
    output logic [QW-1:0] quo
);
    localparam int CNW = $clog2(QW + 1);
    localparam int XW  = W + QW + 1;

    typedef struct packed {
        logic [W-1:0]   rem;
        logic [W-1:0]   num;
        logic [W-1:0]   den;
        logic [QW-1:0]  quo;
        logic [CNW-1:0] cnt;
        logic           busy;
        logic           done;
    } dv_t;

    dv_t  dv_d, dv_q;
    logic [W:0] trial;

    always_comb begin
        dv_d      = dv_q;
        dv_d.done = 1'b0;
        trial     = {dv_q.rem, 1'b0};
        if (start) begin
            dv_d.rem  = num;
            dv_d.num  = num;
            dv_d.den  = den;
            dv_d.quo  = '0;
            dv_d.cnt  = '0;
            dv_d.busy = 1'b1;
        end else if (dv_q.busy) begin
            if (trial >= {1'b0, dv_q.den}) begin
                dv_d.rem = W'(trial - {1'b0, dv_q.den});
                dv_d.quo = {dv_q.quo[QW-2:0], 1'b1};
            end else begin
                dv_d.rem = trial[W-1:0];
                dv_d.quo = {dv_q.quo[QW-2:0], 1'b0};
            end
            dv_d.cnt = dv_q.cnt + 1'b1;
            if (dv_q.cnt == CNW'(QW - 1)) begin
                dv_d.busy = 1'b0;
                dv_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign done = dv_q.done;
    assign quo  = dv_q.quo;

    AST_DIV_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        dv_q.done |-> ((XW'(dv_q.quo) * XW'(dv_q.den) <= (XW'(dv_q.num) << QW)) &&
                       ((XW'(dv_q.quo) + XW'(1)) * XW'(dv_q.den) > (XW'(dv_q.num) << QW)))); // R3

endmodule

// File: rtl/sse_isqrt.sv
// Bit-serial integer square root, two radicand bits per cycle.
module sse_isqrt #(
    parameter int RW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [RW-1:0]   rad,
    output logic            done,
    output logic [RW/2-1:0] root
);
    localparam int HW  = RW / 2;
    localparam int RMW = HW + 4;
    localparam int CNW = $clog2(HW + 1);
    localparam int XW  = RW + 4;

    typedef struct packed {
        logic [RW-1:0]  rad;
        logic [RW-1:0]  rad0;
        logic [RMW-1:0] rem;
        logic [HW-1:0]  root;
        logic [CNW-1:0] cnt;
        logic           busy;
        logic           done;
    } sq_t;

    sq_t sq_d, sq_q;
    logic [RMW-1:0] rem_sh;
    logic [RMW-1:0] trial;

    always_comb begin
        sq_d      = sq_q;
        sq_d.done = 1'b0;
        rem_sh    = {sq_q.rem[RMW-3:0], sq_q.rad[RW-1:RW-2]};
        trial     = RMW'({sq_q.root, 2'b01});
        if (start) begin
            sq_d.rad  = rad;
            sq_d.rad0 = rad;
            sq_d.rem  = '0;
            sq_d.root = '0;
            sq_d.cnt  = '0;
            sq_d.busy = 1'b1;
        end else if (sq_q.busy) begin
            sq_d.rad = sq_q.rad << 2;
            if (rem_sh >= trial) begin
                sq_d.rem  = rem_sh - trial;
                sq_d.root = {sq_q.root[HW-2:0], 1'b1};
            end else begin
                sq_d.rem  = rem_sh;
                sq_d.root = {sq_q.root[HW-2:0], 1'b0};
            end
            sq_d.cnt = sq_q.cnt + 1'b1;
            if (sq_q.cnt == CNW'(HW - 1)) begin
                sq_d.busy = 1'b0;
                sq_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    assign done = sq_q.done;
    assign root = sq_q.root;

    AST_ROOT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        sq_q.done |-> ((XW'(sq_q.root) * XW'(sq_q.root) <= XW'(sq_q.rad0)) &&
                       ((XW'(sq_q.root) + XW'(1)) * (XW'(sq_q.root) + XW'(1)) > XW'(sq_q.rad0)))); // R3

endmodule

// File: rtl/spec_sub_engine.sv
module spec_sub_engine
    import sse_pkg::*;
#(
    parameter int DW          = 16,
    parameter int BINS        = 64,
    parameter int FRAC_W      = 16,
    parameter int FLOOR_SHIFT = 4,
    parameter int THR_SHIFT   = 1,
    parameter int ALPHA_SHIFT = 3,
    parameter int TRAIN_SHIFT = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic signed [DW-1:0] re_i,
    input  logic signed [DW-1:0] im_i,
    output logic                 ack_o,
    output logic signed [DW-1:0] re_o,
    output logic signed [DW-1:0] im_o
);
    localparam int PW           = 2 * DW;
    localparam int NW           = PW + 3;
    localparam int AW           = $clog2(BINS);
    localparam int SW           = PW + AW;
    localparam int GW           = DW + 1;
    localparam int MW           = DW + GW;
    localparam int RW           = 2 * DW;
    localparam int RAD_SHIFT    = 2 * (DW - 1) - FRAC_W;
    localparam int TRAIN_FRAMES = 1 << TRAIN_SHIFT;
    localparam int CW           = $clog2(TRAIN_FRAMES + 1);
    localparam logic [GW-1:0] FLOOR_GAIN = GW'(1) << (DW - 1 - FLOOR_SHIFT);
    localparam logic [GW-1:0] UNITY_GAIN = GW'(1) << (DW - 1);

    typedef struct packed {
        sse_state_e          state;
        logic signed [DW-1:0] re;
        logic signed [DW-1:0] im;
        logic [PW-1:0]       pwr;
        logic [NW-1:0]       n8;
        logic [PW-1:0]       clean;
        logic [GW-1:0]       gain;
        logic [AW-1:0]       bin;
        logic [AW-1:0]       upd_idx;
        logic [CW-1:0]       frames;
        logic                training;
        logic [SW-1:0]       sum_x;
        logic [SW-1:0]       sum_s;
        logic                div_start;
        logic                sq_start;
        logic                ack;
        logic signed [DW-1:0] re_out;
        logic signed [DW-1:0] im_out;
    } regs_t;

    regs_t r_d, r_q;

    // memories
    logic          nz_we, fb_we;
    logic [AW-1:0] nz_raddr, nz_waddr, fb_waddr;
    logic [PW-1:0] nz_wdata, fb_wdata, nz_rdata, fb_rdata;

    // iterative units
    logic              div_done, sq_done;
    logic [FRAC_W-1:0] div_quo;
    logic [DW-1:0]     sq_root;
    logic [FRAC_W:0]   keep_frac;
    logic [RW-1:0]     sq_rad;

    // datapath helpers
    logic signed [PW-1:0] sq_re_in, sq_im_in;
    logic [PW-1:0]        pwr_in;
    logic [NW-1:0]        n8_in;
    logic signed [MW-1:0] prod_re, prod_im, sh_re, sh_im;
    logic [SW-1:0]        sx_nx, ss_nx;
    logic                 quiet_frame, train_frame;

    assign sq_re_in  = re_i * re_i;
    assign sq_im_in  = im_i * im_i;
    assign pwr_in    = $unsigned(sq_re_in) + $unsigned(sq_im_in);
    assign n8_in     = {nz_rdata, 3'b000};
    assign keep_frac = {1'b1, {FRAC_W{1'b0}}} - {1'b0, div_quo};
    assign sq_rad    = RW'(keep_frac) << RAD_SHIFT;
    assign prod_re   = r_q.re * $signed(r_q.gain);
    assign prod_im   = r_q.im * $signed(r_q.gain);
    assign sh_re     = prod_re >>> (DW - 1);
    assign sh_im     = prod_im >>> (DW - 1);

    always_comb begin
        r_d           = r_q;
        r_d.ack       = 1'b0;
        r_d.div_start = 1'b0;
        r_d.sq_start  = 1'b0;
        nz_raddr      = (r_q.state == S_UPD) ? r_q.upd_idx : r_q.bin;
        nz_we         = 1'b0;
        nz_waddr      = r_q.upd_idx;
        nz_wdata      = '0;
        fb_we         = 1'b0;
        fb_waddr      = r_q.bin;
        fb_wdata      = r_q.pwr;
        sx_nx         = r_q.sum_x + SW'(r_q.pwr);
        ss_nx         = r_q.sum_s + SW'(r_q.clean);
        quiet_frame   = ss_nx < (sx_nx >> THR_SHIFT);
        train_frame   = r_q.frames < CW'(TRAIN_FRAMES);

        unique case (r_q.state)
            S_IDLE: begin
                if (load_i) begin
                    r_d.re  = re_i;
                    r_d.im  = im_i;
                    r_d.pwr = pwr_in;
                    r_d.n8  = n8_in;
                    if (n8_in >= NW'(pwr_in)) begin
                        r_d.gain  = FLOOR_GAIN;
                        r_d.clean = pwr_in >> (2 * FLOOR_SHIFT);
                        r_d.state = S_OUT;
                    end else begin
                        r_d.clean     = pwr_in - n8_in[PW-1:0];
                        r_d.div_start = 1'b1;
                        r_d.state     = S_DIV;
                    end
                end
            end
            S_DIV: begin
                if (div_done) begin
                    r_d.sq_start = 1'b1;
                    r_d.state    = S_SQRT;
                end
            end
            S_SQRT: begin
                if (sq_done) begin
                    r_d.gain  = {1'b0, sq_root};
                    r_d.state = S_OUT;
                end
            end
            S_OUT: begin
                r_d.ack    = 1'b1;
                r_d.re_out = sh_re[DW-1:0];
                r_d.im_out = sh_im[DW-1:0];
                fb_we      = 1'b1;
                r_d.state  = S_IDLE;
                if (r_q.bin == AW'(BINS - 1)) begin
                    r_d.bin   = '0;
                    r_d.sum_x = '0;
                    r_d.sum_s = '0;
                    if (train_frame) r_d.frames = r_q.frames + 1'b1;
                    if (train_frame || quiet_frame) begin
                        r_d.training = train_frame;
                        r_d.upd_idx  = '0;
                        r_d.state    = S_UPD;
                    end
                end else begin
                    r_d.bin   = r_q.bin + 1'b1;
                    r_d.sum_x = sx_nx;
                    r_d.sum_s = ss_nx;
                end
            end
            S_UPD: begin
                nz_we = 1'b1;
                if (r_q.training)
                    nz_wdata = nz_rdata + (fb_rdata >> TRAIN_SHIFT);
                else
                    nz_wdata = nz_rdata - (nz_rdata >> ALPHA_SHIFT) + (fb_rdata >> ALPHA_SHIFT);
                r_d.upd_idx = r_q.upd_idx + 1'b1;
                if (r_q.upd_idx == AW'(BINS - 1)) r_d.state = S_IDLE;
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    sse_bin_ram #(.DEPTH(BINS), .WIDTH(PW)) u_noise_ram (
        .clk(clk), .rst_n(rst_n), .we(nz_we), .waddr(nz_waddr), .wdata(nz_wdata),
        .raddr(nz_raddr), .rdata(nz_rdata)
    );

    sse_bin_ram #(.DEPTH(BINS), .WIDTH(PW)) u_frame_ram (
        .clk(clk), .rst_n(rst_n), .we(fb_we), .waddr(fb_waddr), .wdata(fb_wdata),
        .raddr(r_q.upd_idx), .rdata(fb_rdata)
    );

    sse_frac_div #(.W(PW), .QW(FRAC_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(r_q.div_start),
        .num(r_q.n8[PW-1:0]), .den(r_q.pwr), .done(div_done), .quo(div_quo)
    );

    sse_isqrt #(.RW(RW)) u_sqrt (
        .clk(clk), .rst_n(rst_n), .start(r_q.sq_start), .rad(sq_rad),
        .done(sq_done), .root(sq_root)
    );

    assign ack_o = r_q.ack;
    assign re_o  = r_q.re_out;
    assign im_o  = r_q.im_out;

    function automatic logic [DW:0] mag(input logic signed [DW-1:0] v);
        logic signed [DW:0] e;
        e = v;
        return (e < 0) ? $unsigned(-e) : $unsigned(e);
    endfunction

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o); // R4

    AST_GAIN_LE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_OUT) |-> (r_q.gain <= UNITY_GAIN)); // R3

    AST_FLOOR_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.state == S_OUT) && (r_q.n8 >= NW'(r_q.pwr))) |-> (r_q.gain == FLOOR_GAIN)); // R2

    AST_NO_AMPLIFY: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> ((mag(re_o) <= mag(r_q.re)) && (mag(im_o) <= mag(r_q.im)))); // R4

    AST_UPD_AT_BIN0: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_UPD) |-> (r_q.bin == '0)); // R5

    AST_UPD_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.state == S_UPD) && load_i) |=> !ack_o); // R9

endmodule

// File: tb/sim_spec_sub_engine.sv
module sim_spec_sub_engine;
    localparam int BINS = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_i = 1'b0;
    logic signed [15:0] re_i = '0;
    logic signed [15:0] im_i = '0;
    logic ack_o;
    logic signed [15:0] re_o, im_o;

    always #10 clk = ~clk;

    spec_sub_engine u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .re_i(re_i), .im_i(im_i),
        .ack_o(ack_o), .re_o(re_o), .im_o(im_o)
    );

    typedef struct {
        logic signed [15:0] re;
        logic signed [15:0] im;
        string              tag;
    } exp_t;

    exp_t   sb[$];
    exp_t   mon_e;
    int     checks = 0;
    int     fails = 0;
    bit     ended = 1'b0;
    bit     poke_upd = 1'b0;

    longint noise[BINS];
    longint fbuf[BINS];
    longint sum_x = 0, sum_s = 0;
    int     frame_cnt = 0;
    int     mbin = 0;

    function automatic longint isq(input longint v);
        longint r = 0;
        for (int b = 18; b >= 0; b--) begin
            longint t = r | (longint'(1) << b);
            if (t * t <= v) r = t;
        end
        return r;
    endfunction

    function automatic logic signed [15:0] rnd(input int amp);
        return 16'($signed($urandom_range(0, 2 * amp)) - amp);
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // Monitor: pop and compare on every acknowledge.
    always @(negedge clk) begin
        if (rst_n && ack_o) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R9/R10: unexpected ack, actual re=%0d im=%0d, expected no ack", re_o, im_o);
            end else begin
                mon_e = sb.pop_front();
                if (re_o !== mon_e.re || im_o !== mon_e.im) begin
                    fails++;
                    $display("FAIL %s: actual re=%0d im=%0d, expected re=%0d im=%0d",
                             mon_e.tag, re_o, im_o, mon_e.re, mon_e.im);
                end
            end
        end
    end

    // Model update at the end of a frame (R6, R7, R8).
    task automatic model_frame_end();
        bit train;
        train = frame_cnt < 8;
        if (train) begin
            for (int k = 0; k < BINS; k++) noise[k] = noise[k] + (fbuf[k] >>> 3);
            frame_cnt++;
        end else if (sum_s < (sum_x >>> 1)) begin
            for (int k = 0; k < BINS; k++) noise[k] = noise[k] - (noise[k] >>> 3) + (fbuf[k] >>> 3);
        end
        sum_x = 0;
        sum_s = 0;
        mbin  = 0;
    endtask

    // Driver: compute expected, push, present bin, wait for acknowledge.
    task automatic send_bin(input logic signed [15:0] r, input logic signed [15:0] i,
                            input string tag, input bit extra);
        longint p, n8, g, cl, fr;
        exp_t e;
        p  = longint'(r) * longint'(r) + longint'(i) * longint'(i);
        n8 = noise[mbin] * 8;
        if (n8 >= p) begin
            g  = 2048;
            cl = p >>> 8;
            e.tag = (tag == "") ? "R2" : tag;
        end else begin
            fr = (n8 << 16) / p;
            g  = isq((65536 - fr) << 14);
            cl = p - n8;
            e.tag = (tag == "") ? "R3" : tag;
        end
        e.re = 16'((longint'(r) * g) >>> 15);
        e.im = 16'((longint'(i) * g) >>> 15);
        sb.push_back(e);
        fbuf[mbin] = p;
        sum_x += p;
        sum_s += cl;
        mbin++;

        @(negedge clk);
        load_i = 1'b1; re_i = r; im_i = i;
        @(negedge clk);
        if (extra) begin
            // R10: second load while the first bin is in processing
            re_i = ~r; im_i = ~i;
            @(negedge clk);
        end
        load_i = 1'b0;
        while (!ack_o) @(negedge clk);

        if (mbin == BINS) begin
            model_frame_end();
            if (poke_upd) begin
                // R9: load inside the update window
                @(negedge clk);
                load_i = 1'b1; re_i = 16'sd1234; im_i = -16'sd999;
                @(negedge clk);
                load_i = 1'b0;
            end
            repeat (72) @(negedge clk);
            if (poke_upd) begin
                checks++;
                if (sb.size() != 0) begin
                    fails++;
                    $display("FAIL R9: actual pending=%0d, expected 0", sb.size());
                end
                poke_upd = 1'b0;
            end
        end
    endtask

    task automatic send_frame(input int amp, input string tag);
        for (int k = 0; k < BINS; k++) send_bin(rnd(amp), rnd(amp), tag, 1'b0);
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout, expected completion");
        finish_run();
    end

    initial begin
        for (int k = 0; k < BINS; k++) begin noise[k] = 0; fbuf[k] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (ack_o !== 1'b0 || re_o !== 16'sd0 || im_o !== 16'sd0) begin
            fails++;
            $display("FAIL R1: actual ack=%0b re=%0d im=%0d, expected 0 0 0", ack_o, re_o, im_o);
        end

        // Frame 0: zero noise, so bins pass unchanged (bin 5 has zero power).
        for (int k = 0; k < BINS; k++) begin
            if (k == 5) send_bin(16'sd0, 16'sd0, "R1", 1'b0);
            else        send_bin(rnd(400), rnd(400), "R1", 1'b0);
        end
        // Frames 1..7: rest of the averaging phase.
        for (int f = 1; f < 8; f++) send_frame(400, "R6");
        // Frame 8: noise-like, path-dependent tags; update window is poked.
        poke_upd = 1'b1;
        send_frame(400, "");
        // Frame 9: result depends on the adaptive update and on bin 0 restart.
        for (int k = 0; k < BINS; k++) send_bin(rnd(400), rnd(400), (k < 32) ? "R5" : "R8", 1'b0);
        // Frame 10: loud frame with an extreme bin and a double load.
        for (int k = 0; k < BINS; k++) begin
            if (k == 0)      send_bin(16'sd20000, -16'sd15000, "R10", 1'b1);
            else if (k == 1) send_bin(-16'sd32768, -16'sd32768, "R4", 1'b0);
            else             send_bin(rnd(16000), rnd(16000), "R4", 1'b0);
        end
        // Frame 11: estimate must be untouched by the loud frame.
        send_frame(400, "R7");
        // Frame 12: another noise frame after normal operation.
        send_frame(600, "");

        repeat (20) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R10: actual pending=%0d, expected 0", sb.size());
        end
        finish_run();
    end

endmodule